// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a video output path. A pixel counter and a line counter run through a frame whose geometry is set entirely from configuration inputs: pixels per line, lines per frame, and, for interlaced operation, the length of the first field. The second field takes the lines that remain. From the two counters the block decodes a horizontal sync, a vertical sync, a field identifier and a blanking flag. It also decodes a composite sync whose shape during vertical sync lines depends on a selectable line-type mode. The composite sync can be inserted on the luma channel only or on all three channels. Every output comes from a register.

In master operation the counters run free. In slave operation they lock to an external reference. That reference is either the rising edges of dedicated horizontal and vertical sync pins, together with a field pin, or single-cycle strobes decoded upstream from embedded timing codes, together with a field flag. On a reference, the matching counter loads a programmed offset, which places the generated frame relative to the incoming sync.

Top module: `vtg_top`

## Requirements
- R1: While `rst` is high at a clock edge, both counters clear, and every output is 0 after that edge.
- R2: In master operation the pixel counter counts 0 to `cfg_total_px`-1 and then wraps to 0. The line counter advances by one at each wrap and returns to 0 after line `cfg_frame_lines`-1. As a result, the horizontal sync repeats every `cfg_total_px` cycles and, in progressive operation, the vertical sync repeats every `cfg_total_px`×`cfg_frame_lines` cycles.
- R3: The horizontal sync is active for pixels 0 to `cfg_hs_width`-1. With `cfg_hs_pol`=1 the active level is high; with 0 it is low.
- R4: The vertical sync is active for field-relative lines 0 to `cfg_vs_lines`-1 in each field. `cfg_vs_pol` selects its active level in the same way as `cfg_hs_pol`.
- R5: With `cfg_interlaced`=1, `fid_o` is 1 on lines `cfg_field1_lines` and above, so it changes only at field boundaries, and field-relative lines restart at 0 in the second field. With `cfg_interlaced`=0, `fid_o` stays 0 and the whole frame is one field.
- R6: `blank_o` is high when the pixel index is at or beyond `cfg_active_px`, or when the field-relative line is below `cfg_vblank_lines`.
- R7: The composite sync follows `cfg_mode`. With 2 or 3, it equals the active horizontal sync. With 1, it is active for the whole of each vertical sync line and equals the horizontal sync on other lines. With 0, it is the inverse of the horizontal sync on vertical sync lines and equals the horizontal sync on other lines.
- R8: `sync_y_o` is the active-high composite sync gated by `cfg_cs_en`. `sync_c_o` is also gated by `cfg_cs_all`, so it is never high unless `sync_y_o` is high.
- R9: In slave operation a horizontal reference loads `cfg_h_delay` into the pixel counter. A horizontal reference is a rising edge of `hs_in` when `cfg_ref_emb`=0, and a high `emb_h_stb` when `cfg_ref_emb`=1. A level held high on `hs_in` does not load again.
- R10: In slave operation a vertical reference loads `cfg_v_delay` into the line counter. A vertical reference is a rising edge of `vs_in` or a high `emb_v_stb`, selected the same way as in R9. In interlaced operation, `cfg_field1_lines` is added to the loaded value when the field flag is 1. The field flag is `fid_in` for dedicated references and `emb_fid` for embedded ones.
- R11: References from the source not selected by `cfg_ref_emb` have no effect, and in master operation (`cfg_slave`=0) all references are ignored.
- R12: When a vertical reference falls in the same cycle as a pixel-counter wrap, the loaded line value wins over the line advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_total_px | input | PX_W | Pixels per line |
| cfg_active_px | input | PX_W | First pixel of horizontal blanking |
| cfg_hs_width | input | PX_W | Horizontal sync width in pixels |
| cfg_frame_lines | input | LN_W | Lines per frame |
| cfg_field1_lines | input | LN_W | Lines in the first field (interlaced) |
| cfg_vs_lines | input | LN_W | Vertical sync length in lines per field |
| cfg_vblank_lines | input | LN_W | Vertical blanking length in lines per field |
| cfg_interlaced | input | 1 | 1 = two fields per frame |
| cfg_mode | input | 2 | Line-type mode: 0 serrated, 1 broad, 2/3 separate |
| cfg_hs_pol | input | 1 | Horizontal sync active level |
| cfg_vs_pol | input | 1 | Vertical sync active level |
| cfg_cs_en | input | 1 | Composite sync insertion enable |
| cfg_cs_all | input | 1 | 1 = insert on all channels, 0 = luma only |
| cfg_slave | input | 1 | 1 = lock counters to references |
| cfg_ref_emb | input | 1 | 1 = embedded strobes, 0 = dedicated pins |
| cfg_h_delay | input | PX_W | Pixel value loaded on a horizontal reference |
| cfg_v_delay | input | LN_W | Line value loaded on a vertical reference |
| hs_in | input | 1 | Dedicated horizontal reference |
| vs_in | input | 1 | Dedicated vertical reference |
| fid_in | input | 1 | Dedicated field flag |
| emb_h_stb | input | 1 | Decoded embedded horizontal strobe |
| emb_v_stb | input | 1 | Decoded embedded vertical strobe |
| emb_fid | input | 1 | Decoded embedded field flag |
| hs_o | output | 1 | Horizontal sync |
| vs_o | output | 1 | Vertical sync |
| fid_o | output | 1 | Field identifier |
| blank_o | output | 1 | Blanking interval |
| sync_y_o | output | 1 | Composite sync for the luma channel |
| sync_c_o | output | 1 | Composite sync for the two colour channels |

## Verification
A vertical reference and the natural end of a line can arrive in the same cycle. In that cycle the line counter must choose between loading the programmed offset and advancing by one. The bench first locks the pixel counter with a horizontal reference so that it sits two pixels before its wrap. It then raises `vs_in` so that the edge is sampled exactly on the wrap cycle, with an offset one line below the second field. The result is judged at the outputs: `fid_o` must stay low for one more full line and rise on exactly the cycle after the next wrap. During this test the horizontal reference stays high, which also shows that a held level does not reload the counter.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum logic [1:0] {
    MODE_SERRATED = 2'd0,
    MODE_BROAD    = 2'd1,
    MODE_SEPARATE = 2'd2,
    MODE_SEP_ALT  = 2'd3
  } line_mode_e;

  function automatic logic comp_sync(line_mode_e m, logic h_act, logic v_act);
    logic r;
    case (m)
      MODE_SERRATED: r = v_act ? !h_act : h_act;
      MODE_BROAD:    r = v_act ? 1'b1   : h_act;
      default:       r = h_act;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vtg_ref_qual.sv
module vtg_ref_qual (
  input  logic clk,
  input  logic rst,
  input  logic slave,
  input  logic use_emb,
  input  logic hs_in,
  input  logic vs_in,
  input  logic fid_in,
  input  logic emb_h,
  input  logic emb_v,
  input  logic emb_f,
  output logic h_ref,
  output logic v_ref,
  output logic f_ref
);
  localparam int NREF = 2;

  logic [NREF-1:0] lvl;
  logic [NREF-1:0] stb;
  logic [NREF-1:0] hit;

  assign lvl = {vs_in, hs_in};
  assign stb = {emb_v, emb_h};

  for (genvar i = 0; i < NREF; i++) begin : g_ref
    logic prev_q;
    always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= lvl[i];
    end
    assign hit[i] = slave && (use_emb ? stb[i] : (lvl[i] && !prev_q));
  end

  assign h_ref = hit[0];
  assign v_ref = hit[1];
  assign f_ref = use_emb ? emb_f : fid_in;
endmodule

// File: rtl/vtg_raster_cnt.sv
module vtg_raster_cnt #(
  parameter int PX_W = 12,
  parameter int LN_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PX_W-1:0] total_px,
  input  logic [LN_W-1:0] frame_lines,
  input  logic [LN_W-1:0] field1_lines,
  input  logic            interlaced,
  input  logic [PX_W-1:0] h_delay,
  input  logic [LN_W-1:0] v_delay,
  input  logic            h_ref,
  input  logic            v_ref,
  input  logic            f_ref,
  output logic [PX_W-1:0] px,
  output logic [LN_W-1:0] ln
);
  logic            px_last;
  logic            ln_last;
  logic [LN_W-1:0] v_load;

  assign px_last = px >= (total_px - PX_W'(1));
  assign ln_last = ln >= (frame_lines - LN_W'(1));
  assign v_load  = v_delay + ((interlaced && f_ref) ? field1_lines : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      px <= '0;
      ln <= '0;
    end else begin
      if (h_ref)        px <= h_delay;
      else if (px_last) px <= '0;
      else              px <= px + PX_W'(1);

      if (v_ref)                   ln <= v_load;
      else if (px_last && !h_ref)  ln <= ln_last ? '0 : ln + LN_W'(1);
    end
  end
endmodule

// File: rtl/vtg_sync_dec.sv
module vtg_sync_dec
  import vtg_pkg::*;
#(
  parameter int PX_W = 12,
  parameter int LN_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PX_W-1:0] px,
  input  logic [LN_W-1:0] ln,
  input  logic [PX_W-1:0] active_px,
  input  logic [PX_W-1:0] hs_width,
  input  logic [LN_W-1:0] field1_lines,
  input  logic [LN_W-1:0] vs_lines,
  input  logic [LN_W-1:0] vblank_lines,
  input  logic            interlaced,
  input  logic [1:0]      mode,
  input  logic            hs_pol,
  input  logic            vs_pol,
  input  logic            cs_en,
  input  logic            cs_all,
  output logic            hs_o,
  output logic            vs_o,
  output logic            fid_o,
  output logic            blank_o,
  output logic            sync_y_o,
  output logic            sync_c_o
);
  logic            in_f2;
  logic [LN_W-1:0] fline;
  logic            h_act, v_act, bl_act, cs_act;

  always_comb begin
    in_f2  = interlaced && (ln >= field1_lines);
    fline  = in_f2 ? (ln - field1_lines) : ln;
    h_act  = px < hs_width;
    v_act  = fline < vs_lines;
    bl_act = (px >= active_px) || (fline < vblank_lines);
    cs_act = comp_sync(line_mode_e'(mode), h_act, v_act);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_o     <= 1'b0;
      vs_o     <= 1'b0;
      fid_o    <= 1'b0;
      blank_o  <= 1'b0;
      sync_y_o <= 1'b0;
      sync_c_o <= 1'b0;
    end else begin
      hs_o     <= !(h_act ^ hs_pol);
      vs_o     <= !(v_act ^ vs_pol);
      fid_o    <= in_f2;
      blank_o  <= bl_act;
      sync_y_o <= cs_en && cs_act;
      sync_c_o <= cs_en && cs_all && cs_act;
    end
  end
endmodule

// File: rtl/vtg_top.sv
module vtg_top #(
  parameter int PX_W = 12,
  parameter int LN_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PX_W-1:0] cfg_total_px,
  input  logic [PX_W-1:0] cfg_active_px,
  input  logic [PX_W-1:0] cfg_hs_width,
  input  logic [LN_W-1:0] cfg_frame_lines,
  input  logic [LN_W-1:0] cfg_field1_lines,
  input  logic [LN_W-1:0] cfg_vs_lines,
  input  logic [LN_W-1:0] cfg_vblank_lines,
  input  logic            cfg_interlaced,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_hs_pol,
  input  logic            cfg_vs_pol,
  input  logic            cfg_cs_en,
  input  logic            cfg_cs_all,
  input  logic            cfg_slave,
  input  logic            cfg_ref_emb,
  input  logic [PX_W-1:0] cfg_h_delay,
  input  logic [LN_W-1:0] cfg_v_delay,
  input  logic            hs_in,
  input  logic            vs_in,
  input  logic            fid_in,
  input  logic            emb_h_stb,
  input  logic            emb_v_stb,
  input  logic            emb_fid,
  output logic            hs_o,
  output logic            vs_o,
  output logic            fid_o,
  output logic            blank_o,
  output logic            sync_y_o,
  output logic            sync_c_o
);
  logic            h_ref, v_ref, f_ref;
  logic [PX_W-1:0] px_cnt;
  logic [LN_W-1:0] ln_cnt;

  vtg_ref_qual u_ref (
    .clk(clk), .rst(rst), .slave(cfg_slave), .use_emb(cfg_ref_emb),
    .hs_in(hs_in), .vs_in(vs_in), .fid_in(fid_in),
    .emb_h(emb_h_stb), .emb_v(emb_v_stb), .emb_f(emb_fid),
    .h_ref(h_ref), .v_ref(v_ref), .f_ref(f_ref)
  );

  vtg_raster_cnt #(.PX_W(PX_W), .LN_W(LN_W)) u_cnt (
    .clk(clk), .rst(rst),
    .total_px(cfg_total_px), .frame_lines(cfg_frame_lines),
    .field1_lines(cfg_field1_lines), .interlaced(cfg_interlaced),
    .h_delay(cfg_h_delay), .v_delay(cfg_v_delay),
    .h_ref(h_ref), .v_ref(v_ref), .f_ref(f_ref),
    .px(px_cnt), .ln(ln_cnt)
  );

  vtg_sync_dec #(.PX_W(PX_W), .LN_W(LN_W)) u_dec (
    .clk(clk), .rst(rst), .px(px_cnt), .ln(ln_cnt),
    .active_px(cfg_active_px), .hs_width(cfg_hs_width),
    .field1_lines(cfg_field1_lines), .vs_lines(cfg_vs_lines),
    .vblank_lines(cfg_vblank_lines), .interlaced(cfg_interlaced),
    .mode(cfg_mode), .hs_pol(cfg_hs_pol), .vs_pol(cfg_vs_pol),
    .cs_en(cfg_cs_en), .cs_all(cfg_cs_all),
    .hs_o(hs_o), .vs_o(vs_o), .fid_o(fid_o), .blank_o(blank_o),
    .sync_y_o(sync_y_o), .sync_c_o(sync_c_o)
  );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int PX_W = 12,
  parameter int LN_W = 11
) (
  input logic            clk,
  input logic            rst,
  input logic [PX_W-1:0] cfg_total_px,
  input logic [PX_W-1:0] cfg_h_delay,
  input logic [LN_W-1:0] cfg_v_delay,
  input logic            cfg_interlaced,
  input logic            cfg_slave,
  input logic            h_ref,
  input logic            v_ref,
  input logic            f_ref,
  input logic [PX_W-1:0] px,
  input logic [LN_W-1:0] ln,
  input logic            hs_o,
  input logic            vs_o,
  input logic            fid_o,
  input logic            blank_o,
  input logic            sync_y_o,
  input logic            sync_c_o
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (px == '0 && ln == '0 && !hs_o && !vs_o && !fid_o && !blank_o && !sync_y_o && !sync_c_o));

  a_r2_px_wraps: assert property (@(posedge clk) disable iff (rst)
    (!h_ref && px >= cfg_total_px - PX_W'(1)) |=> (px == '0));

  a_r2_px_steps: assert property (@(posedge clk) disable iff (rst)
    (!h_ref && px < cfg_total_px - PX_W'(1)) |=> (px == $past(px) + PX_W'(1)));

  a_r9_h_load: assert property (@(posedge clk) disable iff (rst)
    h_ref |=> (px == $past(cfg_h_delay)));

  a_r10_v_load: assert property (@(posedge clk) disable iff (rst)
    (v_ref && !(cfg_interlaced && f_ref)) |=> (ln == $past(cfg_v_delay)));

  a_r11_master_no_ref: assert property (@(posedge clk) disable iff (rst)
    !cfg_slave |-> (!h_ref && !v_ref));

  a_r8_chroma_needs_luma: assert property (@(posedge clk) disable iff (rst)
    sync_c_o |-> sync_y_o);

  a_r5_prog_fid_low: assert property (@(posedge clk) disable iff (rst)
    (!cfg_interlaced && $past(!cfg_interlaced)) |-> !fid_o);
endmodule

bind vtg_top vtg_checker #(.PX_W(PX_W), .LN_W(LN_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_total_px(cfg_total_px), .cfg_h_delay(cfg_h_delay),
  .cfg_v_delay(cfg_v_delay), .cfg_interlaced(cfg_interlaced), .cfg_slave(cfg_slave),
  .h_ref(h_ref), .v_ref(v_ref), .f_ref(f_ref), .px(px_cnt), .ln(ln_cnt),
  .hs_o(hs_o), .vs_o(vs_o), .fid_o(fid_o), .blank_o(blank_o),
  .sync_y_o(sync_y_o), .sync_c_o(sync_c_o)
);

// File: tb/vtg_top_bench.sv
module vtg_top_bench;
  localparam int PX_W = 12;
  localparam int LN_W = 11;

  logic clk = 1'b0;
  always #4 clk = !clk;

  logic            rst;
  logic [PX_W-1:0] cfg_total_px, cfg_active_px, cfg_hs_width, cfg_h_delay;
  logic [LN_W-1:0] cfg_frame_lines, cfg_field1_lines, cfg_vs_lines, cfg_vblank_lines, cfg_v_delay;
  logic            cfg_interlaced, cfg_hs_pol, cfg_vs_pol, cfg_cs_en, cfg_cs_all;
  logic            cfg_slave, cfg_ref_emb;
  logic [1:0]      cfg_mode;
  logic            hs_in, vs_in, fid_in, emb_h_stb, emb_v_stb, emb_fid;
  logic            hs_o, vs_o, fid_o, blank_o, sync_y_o, sync_c_o;

  vtg_top #(.PX_W(PX_W), .LN_W(LN_W)) u_vtg_top (
    .clk(clk), .rst(rst),
    .cfg_total_px(cfg_total_px), .cfg_active_px(cfg_active_px), .cfg_hs_width(cfg_hs_width),
    .cfg_frame_lines(cfg_frame_lines), .cfg_field1_lines(cfg_field1_lines),
    .cfg_vs_lines(cfg_vs_lines), .cfg_vblank_lines(cfg_vblank_lines),
    .cfg_interlaced(cfg_interlaced), .cfg_mode(cfg_mode),
    .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
    .cfg_cs_en(cfg_cs_en), .cfg_cs_all(cfg_cs_all),
    .cfg_slave(cfg_slave), .cfg_ref_emb(cfg_ref_emb),
    .cfg_h_delay(cfg_h_delay), .cfg_v_delay(cfg_v_delay),
    .hs_in(hs_in), .vs_in(vs_in), .fid_in(fid_in),
    .emb_h_stb(emb_h_stb), .emb_v_stb(emb_v_stb), .emb_fid(emb_fid),
    .hs_o(hs_o), .vs_o(vs_o), .fid_o(fid_o), .blank_o(blank_o),
    .sync_y_o(sync_y_o), .sync_c_o(sync_c_o)
  );

  int errs = 0;
  int checks = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Columns: total_px, frame_lines, field1, interlaced, hs_width, vs_lines, active_px,
  // vblank_lines, mode, hs_pol, vs_pol, cs_all,
  // expected per frame: hs active, vs active, fid high, blank high, sync_y high, sync_c high
  localparam int NV = 3;
  localparam int VEC [NV][18] = '{
    '{16, 10, 0, 0, 3, 2, 12, 1, 2, 1, 1, 0,   30,  32,   0,  52, 30,  0},
    '{20, 11, 5, 1, 4, 1, 16, 2, 1, 0, 0, 1,   44,  40, 120, 108, 76, 76},
    '{24,  8, 4, 1, 5, 2, 20, 2, 0, 1, 1, 0,   40,  96,  96, 112, 96,  0}
  };

  task automatic load_cfg(input int v, input logic hp, input logic vp);
    cfg_total_px     = PX_W'(VEC[v][0]);
    cfg_frame_lines  = LN_W'(VEC[v][1]);
    cfg_field1_lines = LN_W'(VEC[v][2]);
    cfg_interlaced   = VEC[v][3] != 0;
    cfg_hs_width     = PX_W'(VEC[v][4]);
    cfg_vs_lines     = LN_W'(VEC[v][5]);
    cfg_active_px    = PX_W'(VEC[v][6]);
    cfg_vblank_lines = LN_W'(VEC[v][7]);
    cfg_mode         = 2'(VEC[v][8]);
    cfg_hs_pol       = hp;
    cfg_vs_pol       = vp;
    cfg_cs_all       = VEC[v][11] != 0;
    cfg_cs_en        = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    int n_hs, n_vs, n_fid, n_bl, n_y, n_c, per;
    rst = 1'b1;
    cfg_slave = 1'b0; cfg_ref_emb = 1'b0; cfg_h_delay = '0; cfg_v_delay = '0;
    hs_in = 1'b0; vs_in = 1'b0; fid_in = 1'b0;
    emb_h_stb = 1'b0; emb_v_stb = 1'b0; emb_fid = 1'b0;
    load_cfg(0, 1'b1, 1'b1);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      rst = 1'b1;
      load_cfg(v, VEC[v][9] != 0, VEC[v][10] != 0);
      step(2);
      if (v == 0)
        check("R1 outputs in reset", int'({hs_o, vs_o, fid_o, blank_o, sync_y_o, sync_c_o}), 0);
      rst = 1'b0;
      step(4);
      n_hs = 0; n_vs = 0; n_fid = 0; n_bl = 0; n_y = 0; n_c = 0;
      for (int c = 0; c < VEC[v][0] * VEC[v][1]; c++) begin
        @(negedge clk);
        if (hs_o == cfg_hs_pol) n_hs++;
        if (vs_o == cfg_vs_pol) n_vs++;
        if (fid_o) n_fid++;
        if (blank_o) n_bl++;
        if (sync_y_o) n_y++;
        if (sync_c_o) n_c++;
      end
      check("R3 hsync active cycles/frame", n_hs, VEC[v][12]);
      check("R4 vsync active cycles/frame", n_vs, VEC[v][13]);
      check("R5 field-id high cycles/frame", n_fid, VEC[v][14]);
      check("R6 blank cycles/frame", n_bl, VEC[v][15]);
      check("R7 composite sync cycles/frame", n_y, VEC[v][16]);
      check("R8 colour-channel sync cycles/frame", n_c, VEC[v][17]);

      if (v == 0) begin
        while (hs_o !== 1'b0) @(negedge clk);
        while (hs_o !== 1'b1) @(negedge clk);
        per = 0;
        do begin @(negedge clk); per++; end while (hs_o == 1'b1);
        do begin @(negedge clk); per++; end while (hs_o == 1'b0);
        check("R2 hsync period", per, 16);
        while (vs_o !== 1'b0) @(negedge clk);
        while (vs_o !== 1'b1) @(negedge clk);
        per = 0;
        do begin @(negedge clk); per++; end while (vs_o == 1'b1);
        do begin @(negedge clk); per++; end while (vs_o == 1'b0);
        check("R2 vsync period", per, 160);
      end
    end

    // Slave tests: 20 px x 11 lines, field1 = 5, hs width 4, vs 1 line, active-high syncs
    @(negedge clk);
    rst = 1'b1;
    load_cfg(1, 1'b1, 1'b1);
    step(2);
    rst = 1'b0;
    step(3);

    cfg_slave = 1'b1; cfg_ref_emb = 1'b0; cfg_h_delay = 12'd18;
    step(2);
    hs_in = 1'b1;
    step(3);
    check("R9 dedicated edge, hs before wrap", int'(hs_o), 0);
    step(1);
    check("R9 dedicated edge, hs after wrap", int'(hs_o), 1);

    hs_in = 1'b0;
    step(2);
    cfg_h_delay = 12'd1;
    hs_in = 1'b1;
    step(2);
    check("R9 load 1, hs active", int'(hs_o), 1);
    step(3);
    check("R9 load 1, hs ends at pixel 4", int'(hs_o), 0);

    hs_in = 1'b0; cfg_ref_emb = 1'b1; cfg_h_delay = 12'd18;
    step(2);
    emb_h_stb = 1'b1;
    step(1);
    emb_h_stb = 1'b0;
    hs_in = 1'b1;
    step(2);
    check("R9 embedded strobe, hs before wrap", int'(hs_o), 0);
    step(1);
    check("R11 dedicated edge ignored in embedded select", int'(hs_o), 1);

    cfg_slave = 1'b0; hs_in = 1'b0;
    step(6);
    emb_h_stb = 1'b1;
    step(1);
    emb_h_stb = 1'b0;
    step(3);
    check("R11 strobe ignored in master", int'(hs_o), 0);
    step(10);
    check("R2 free-run phase kept in master", int'(hs_o), 1);

    cfg_slave = 1'b1; cfg_ref_emb = 1'b0; cfg_v_delay = 11'd0; fid_in = 1'b1;
    step(1);
    vs_in = 1'b1;
    step(2);
    check("R10 field flag loads second field", int'(fid_o), 1);
    check("R10 vsync at start of second field", int'(vs_o), 1);
    vs_in = 1'b0; fid_in = 1'b0;
    step(2);
    vs_in = 1'b1;
    step(2);
    check("R10 first-field load, fid", int'(fid_o), 0);
    check("R10 first-field load, vsync", int'(vs_o), 1);

    // R12: vertical reference on the wrap cycle, horizontal reference held high
    vs_in = 1'b0; hs_in = 1'b0;
    cfg_h_delay = 12'd17; cfg_v_delay = 11'd4;
    step(2);
    hs_in = 1'b1;
    step(3);
    vs_in = 1'b1;
    step(1);
    step(1);
    check("R12 loaded line 4, no vsync", int'(vs_o), 0);
    check("R12 loaded line 4, fid low", int'(fid_o), 0);
    step(19);
    check("R12 fid still low at end of line 4", int'(fid_o), 0);
    step(1);
    check("R5 fid rises at field boundary", int'(fid_o), 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule